// File: doc/BRIEF.md
# Serial Pseudo-Random Scan Pattern Generator

This block feeds a chain of launch flip-flops with pseudo-random stimulus. A 32-bit linear feedback shift register is shifted out serially, one bit per clock. A scan-enable output is high for the whole burst. That output also tells the target chain to keep its clock running, so it acts as the chain's clock-gating override. One burst lasts 512 cycles, which is enough to fill two 256-bit rows for launch-on-capture testing.

At every launch the block records the register state that the burst starts from. The caller picks where the next burst starts, using two qualifiers sampled with the start pulse:

- **Load:** start from an external seed.
- **Continue:** start from where the previous burst left off, which gives a new pattern.
- **Replay:** neither qualifier is set. The stored start state is used again, so the same pattern is repeated.

The caller must see `ready_o` high before it pulses `start_i`.

Top module: `scan_pattern_gen`

## Requirements
- R1: After reset `ready_o` is 1 and `scan_en_o` is 0. The register holds the default seed 1, so `scan_bit_o` reads 1.
- R2: A `start_i` sampled while `ready_o` is 1 makes `scan_en_o` 1 and `ready_o` 0 in the next cycle.
- R3: `scan_en_o` stays high for exactly 512 consecutive cycles. `ready_o` returns to 1, and `scan_en_o` drops to 0, in the cycle after the 512th scan bit.
- R4: During a burst, `scan_bit_o` is bit 0 of the register. The register then steps once per cycle as a right-shifting Galois register: next = (s >> 1) XOR (s[0] ? 32'h80200003 : 0). This mask corresponds to taps 32, 22, 2 and 1.
- R5: With `load_seed_i` = 1 at start, the burst begins from `seed_i`.
- R6: A zero `seed_i` is illegal. Loading it starts the burst from the value 1 instead.
- R7: With `advance_i` = 1 and `load_seed_i` = 0 at start, the burst begins from the state reached after the last step of the previous burst.
- R8: With both qualifiers 0 at start, the burst begins from the same start state as the previous burst. Before any burst, that start state is 1.
- R9: When both qualifiers are 1, `load_seed_i` wins over `advance_i`.
- R10: While a burst runs, `start_i`, `load_seed_i`, `advance_i` and `seed_i` have no effect. This applies both to the running bit stream and to the start state kept for a later replay.
- R11: The register state is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch a burst; honoured only while ready_o is 1 |
| load_seed_i | input | 1 | Sampled with start: begin from seed_i |
| advance_i | input | 1 | Sampled with start: continue from the previous end state |
| seed_i | input | 32 | External seed value |
| ready_o | output | 1 | Idle; a start may be issued |
| scan_en_o | output | 1 | Burst in progress; doubles as the clock-gating override for the chain |
| scan_bit_o | output | 1 | Serial pattern bit |

## Verification
The bench runs a sequence of bursts that mixes the three start choices in several orders, and it includes a seed that sets every bit. Each 512-bit stream is compared in full against a reference register model.

Repeating a replay right after a continue tells apart a design that stores the start state from one that stores the end state. The cases where load and continue are both set, and where the seed is zero, expose wrong priority and a missing zero guard. A burst hit with a full set of qualifiers halfway through, followed by a replay, shows whether mid-burst inputs leak into either the stream or the stored start state. A reset issued during a burst confirms that the block returns to idle with the default seed.

// File: rtl/scan_pattern_pkg.sv
package scan_pattern_pkg;
  typedef enum logic [1:0] {
    SRC_REPLAY   = 2'd0,
    SRC_CONTINUE = 2'd1,
    SRC_SEED     = 2'd2
  } start_src_e;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_SHIFT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/scan_lfsr_core.sv
module scan_lfsr_core #(
  parameter int unsigned      WIDTH        = 32,
  parameter logic [WIDTH-1:0] TAP_MASK     = 32'h80200003,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = 32'h1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  input  logic             step_i,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state_q, next_state;

  // right-shifting Galois step; bit 0 leaves as the serial output
  always_comb begin
    next_state = {1'b0, state_q[WIDTH-1:1]};
    if (state_q[0]) next_state = next_state ^ TAP_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= DEFAULT_SEED;
    else if (load_i) state_q <= load_val_i;
    else if (step_i) state_q <= next_state;
  end

  assign state_o = state_q;
endmodule

// File: rtl/scan_start_select.sv
module scan_start_select
  import scan_pattern_pkg::*;
#(
  parameter int unsigned      WIDTH        = 32,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = 32'h1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             launch_i,
  input  logic             load_seed_i,
  input  logic             advance_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic [WIDTH-1:0] cur_state_i,
  output logic [WIDTH-1:0] start_val_o
);
  start_src_e       src;
  logic [WIDTH-1:0] saved_q, seed_safe;

  assign seed_safe = (seed_i == '0) ? DEFAULT_SEED : seed_i;

  always_comb begin
    if (load_seed_i)    src = SRC_SEED;
    else if (advance_i) src = SRC_CONTINUE;
    else                src = SRC_REPLAY;
  end

  always_comb begin
    unique case (src)
      SRC_SEED:     start_val_o = seed_safe;
      SRC_CONTINUE: start_val_o = cur_state_i;
      default:      start_val_o = saved_q;
    endcase
  end

  // start state of the latest burst, kept for replay
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       saved_q <= DEFAULT_SEED;
    else if (launch_i) saved_q <= start_val_o;
  end
endmodule

// File: rtl/scan_sequencer.sv
module scan_sequencer
  import scan_pattern_pkg::*;
#(
  parameter int unsigned LEN_LG = 9
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic launch_o,
  output logic step_o,
  output logic scan_en_o,
  output logic ready_o
);
  seq_state_e        state_q;
  logic [LEN_LG-1:0] cnt_q;
  logic              last;

  assign last     = (cnt_q == {LEN_LG{1'b1}});
  assign launch_o = (state_q == SEQ_IDLE) && start_i;
  assign step_o   = (state_q == SEQ_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_SHIFT;
          cnt_q   <= '0;
        end
        SEQ_SHIFT: begin
          cnt_q <= cnt_q + 1'b1;
          if (last) state_q <= SEQ_IDLE;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign scan_en_o = (state_q == SEQ_SHIFT);
  assign ready_o   = (state_q == SEQ_IDLE);
endmodule

// File: rtl/scan_pattern_gen.sv
module scan_pattern_gen #(
  parameter int unsigned      WIDTH        = 32,
  parameter logic [WIDTH-1:0] TAP_MASK     = 32'h80200003,
  parameter logic [WIDTH-1:0] DEFAULT_SEED = 32'h1,
  parameter int unsigned      LEN_LG       = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             load_seed_i,
  input  logic             advance_i,
  input  logic [WIDTH-1:0] seed_i,
  output logic             ready_o,
  output logic             scan_en_o,
  output logic             scan_bit_o
);
  logic             launch, step;
  logic [WIDTH-1:0] lfsr_q, start_val;

  scan_sequencer #(.LEN_LG(LEN_LG)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .launch_o  (launch),
    .step_o    (step),
    .scan_en_o (scan_en_o),
    .ready_o   (ready_o)
  );

  scan_start_select #(.WIDTH(WIDTH), .DEFAULT_SEED(DEFAULT_SEED)) u_sel (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .launch_i    (launch),
    .load_seed_i (load_seed_i),
    .advance_i   (advance_i),
    .seed_i      (seed_i),
    .cur_state_i (lfsr_q),
    .start_val_o (start_val)
  );

  scan_lfsr_core #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK), .DEFAULT_SEED(DEFAULT_SEED)) u_lfsr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (launch),
    .load_val_i (start_val),
    .step_i     (step),
    .state_o    (lfsr_q)
  );

  assign scan_bit_o = lfsr_q[0];
endmodule

// File: rtl/scan_pattern_gen_chk.sv
module scan_pattern_gen_chk #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned LEN_LG = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             ready_o,
  input logic             scan_en_o,
  input logic [WIDTH-1:0] lfsr_q
);
  localparam int unsigned RUN_LEN = 1 << LEN_LG;

  logic [LEN_LG:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= '0;
    else if (scan_en_o) run_q <= run_q + 1'b1;
    else                run_q <= '0;
  end

  assert_launch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> (scan_en_o && !ready_o));

  assert_idle_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ready_o);

  assert_burst_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(scan_en_o) |-> (run_q == RUN_LEN[LEN_LG:0]));

  assert_burst_max_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_en_o |-> (run_q < RUN_LEN[LEN_LG:0]));

  assert_nonzero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
endmodule

bind scan_pattern_gen scan_pattern_gen_chk #(.WIDTH(WIDTH), .LEN_LG(LEN_LG)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .ready_o   (ready_o),
  .scan_en_o (scan_en_o),
  .lfsr_q    (lfsr_q)
);

// File: tb/scan_pattern_gen_tb_top.sv
module scan_pattern_gen_tb_top;
  localparam int          LEN  = 512;
  localparam logic [31:0] MASK = 32'h80200003;
  localparam int          NVEC = 11;
  // {poke, load, advance, seed}
  localparam logic [34:0] VECS [NVEC] = '{
    {3'b000, 32'h0},
    {3'b001, 32'h0},
    {3'b001, 32'h0},
    {3'b000, 32'h0},
    {3'b010, 32'hDEADBEEF},
    {3'b100, 32'h0},
    {3'b000, 32'h0},
    {3'b011, 32'h12345678},
    {3'b010, 32'h0},
    {3'b001, 32'h0},
    {3'b010, 32'hFFFFFFFF}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, load_seed_i = 1'b0, advance_i = 1'b0;
  logic [31:0] seed_i = 32'h0;
  logic ready_o, scan_en_o, scan_bit_o;
  int n_chk = 0, n_fail = 0;
  logic [31:0] m_cur = 32'h1, m_saved = 32'h1;

  always #2.5 clk = ~clk;

  scan_pattern_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .load_seed_i(load_seed_i),
    .advance_i(advance_i), .seed_i(seed_i), .ready_o(ready_o),
    .scan_en_o(scan_en_o), .scan_bit_o(scan_bit_o)
  );

  function automatic logic [31:0] step(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? MASK : 32'h0);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_burst(input bit ld, input bit adv, input bit poke,
                           input logic [31:0] seed, input string tag);
    logic [LEN-1:0] got, exp;
    logic [31:0] s;
    int highs, first;
    while (!ready_o) @(negedge clk);
    if (ld)       s = (seed == 0) ? 32'h1 : seed;
    else if (adv) s = m_cur;
    else          s = m_saved;
    m_saved = s;
    for (int i = 0; i < LEN; i++) begin
      exp[i] = s[0];
      s = step(s);
    end
    m_cur = s;
    start_i = 1'b1; load_seed_i = ld; advance_i = adv; seed_i = seed;
    @(negedge clk);
    start_i = 1'b0; load_seed_i = 1'b0; advance_i = 1'b0; seed_i = 32'h0BADF00D;
    chk(scan_en_o && !ready_o, "R2 launch", {scan_en_o, ready_o}, 2'b10);
    highs = 0;
    for (int i = 0; i < LEN; i++) begin
      got[i] = scan_bit_o;
      if (scan_en_o && !ready_o) highs++;
      if (poke && i == 100) begin
        start_i = 1'b1; load_seed_i = 1'b1; advance_i = 1'b1; seed_i = 32'h5A5A5A5A;
      end else if (poke && i == 101) begin
        start_i = 1'b0; load_seed_i = 1'b0; advance_i = 1'b0;
      end
      @(negedge clk);
    end
    chk(highs == LEN, "R3 burst length", highs, LEN);
    chk(!scan_en_o && ready_o, "R3 ready return", {scan_en_o, ready_o}, 2'b01);
    first = -1;
    for (int i = LEN - 1; i >= 0; i--) if (got[i] != exp[i]) first = i;
    chk(first < 0, tag, first < 0 ? 0 : {got[first], 8'h0} | first,
        first < 0 ? 0 : {exp[first], 8'h0} | first);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ready_o && !scan_en_o && scan_bit_o, "R1 reset state",
        {ready_o, scan_en_o, scan_bit_o}, 3'b101);
    @(negedge clk);
    chk(ready_o, "R1 idle hold", ready_o, 1);

    for (int v = 0; v < NVEC; v++) begin
      string tag;
      logic [34:0] e;
      e = VECS[v];
      if (e[34])      tag = "R10 stream under mid-burst inputs (R4)";
      else if (e[33]) tag = (e[31:0] == 0) ? "R6 zero seed stream (R4)"
                          : (e[32] ? "R9 load over advance (R4)" : "R5 seed stream (R4)");
      else if (e[32]) tag = "R7 continue stream (R4)";
      else            tag = "R8 replay stream (R4)";
      run_burst(e[33], e[32], e[34], e[31:0], tag);
    end

    // reset during a burst returns to idle and the default start state
    start_i = 1'b1; load_seed_i = 1'b1; seed_i = 32'hCAFE0001;
    @(negedge clk);
    start_i = 1'b0; load_seed_i = 1'b0;
    repeat (40) @(negedge clk);
    rst_ni = 1'b0;
    @(negedge clk);
    chk(ready_o && !scan_en_o && scan_bit_o, "R1 reset mid-burst",
        {ready_o, scan_en_o, scan_bit_o}, 3'b101);
    rst_ni = 1'b1;
    m_cur = 32'h1; m_saved = 32'h1;
    @(negedge clk);
    run_burst(1'b0, 1'b0, 1'b0, 32'h0, "R8 replay after reset (R1)");

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule